// File: doc/BRIEF.md
# Host Command Decoder with Accumulator

This block sits between a host link and a target memory. The host sends 32-bit command words over a valid/ready word stream; the link's byte framing (serial or shift-register based) is handled elsewhere. Each word carries an 8-bit opcode in bits [7:0] and a 24-bit immediate in bits [31:8]. The decoder keeps a 32-bit accumulator. The accumulator serves as a value the host can build up and read back, and as an address pointer for indirect and burst memory transfers. Memory traffic goes out on a request/acknowledge port. Read results and query answers return to the host on a second valid/ready word stream.

Opcodes that control the neighbouring blocks are not handled here. These are the clock-step, clock-stop, clock-resume, core-reset, timeout, page-size, test-start, breakpoint, priority-change and run-to-breakpoint commands. The decoder passes each one on as a one-cycle strobe that carries the opcode and an argument. A callback output tells a link master when the decoder can take a word or holds an answer. Any data phase always follows its command word.

The control is a five-state machine:
- `ST_IDLE` takes a command. It moves to `ST_DATA` for data-bearing writes, to `ST_WRITE` for writes whose data is already known, to `ST_READ` for memory reads and to `ST_SEND` for register queries. Every other command stays in `ST_IDLE`.
- `ST_DATA` takes one data word and moves to `ST_WRITE`.
- `ST_WRITE` waits for the acknowledge. It then returns to `ST_IDLE` after the last word, or to `ST_DATA` for the next burst word.
- `ST_READ` waits for the acknowledge and moves to `ST_SEND`.
- `ST_SEND` waits for the host to take the word. It then returns to `ST_IDLE` after the last word, or to `ST_READ` for the next burst word.

Top module: `host_cmd_decoder`

## Requirements
- R1: An opcode outside every set listed in R2 to R9 is consumed in one cycle. It produces no response, no memory request, no sibling strobe and no accumulator change.
- R2: The accumulator resets to 0. Opcode 0x55 replaces accumulator bits [31:8] with the immediate. Opcode 0x6C replaces bits [7:0] with immediate bits [7:0]. Opcode 0x61 returns the accumulator as one response word.
- R3: Opcode 0x41 sign-extends the 24-bit immediate to 32 bits and adds it to the accumulator, modulo 2^32.
- R4: Opcode 0x57 takes the next input word as data and writes it to the zero-extended immediate address. Opcode 0x4C returns the word stored at the zero-extended immediate address.
- R5: Opcode 0x77 writes the accumulator to the immediate address. Opcode 0x73 writes the zero-extended immediate to the address held in the accumulator.
- R6: Opcode 0x65 with count N (the immediate) writes the next N input words to addresses acc, acc+1, …, acc+N-1. With N = 0 it consumes no further word. The accumulator is unchanged.
- R7: Opcode 0x62 with count N returns N response words, read in order from acc to acc+N-1. With N = 0 it returns nothing.
- R8: Opcode 0x70 returns the identification word given by the `ID_WORD` parameter.
- R9: Each sibling opcode (0x43, 0x53, 0x72, 0x52, 0x54, 0x50, 0x45, 0x44, 0x4F, 0x75) raises `sib_stb` for one cycle, in the cycle after the command is accepted. At the same time `sib_op` carries the opcode and `sib_arg` carries the zero-extended immediate. Opcode 0x64 does the same, except that `sib_arg` carries the accumulator. None of these produces a response.
- R10: Once `mem_req` rises, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high.
- R11: While a response is pending, `rsp_valid` stays high and `rsp_data` is unchanged until `rsp_ready`. `cmd_ready` is low whenever a response is pending or a memory request is active.
- R12: `callback` is high exactly when an input word can be accepted or a response word is waiting.
- R13: One clock after reset is applied: `cmd_ready` is 1, and `rsp_valid`, `mem_req` and `sib_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Input word offered |
| cmd_ready | output | 1 | Input word accepted on this edge if valid |
| cmd_data | input | 32 | Command or data word |
| rsp_valid | output | 1 | Response word waiting |
| rsp_ready | input | 1 | Host takes the response word |
| rsp_data | output | 32 | Response word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| sib_stb | output | 1 | One-cycle strobe to sibling blocks |
| sib_op | output | 8 | Opcode of the forwarded command |
| sib_arg | output | 32 | Argument of the forwarded command |
| callback | output | 1 | Ready for a word or answer waiting |

## Verification
The assertions take two things for granted about the inputs:
- `mem_ack` is high only while `mem_req` is high, and it lasts one cycle for each request.
- After a memory request completes, the host no longer expects the decoder to hold an input word.

The bench keeps within these limits. Its memory model raises the acknowledge only for an open request, after a programmable number of wait cycles, and never twice for the same request. Every input and `rsp_ready` is driven on the falling edge, and the next word is offered only after the previous transfer has completed.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
    localparam int WORD_W = 32;
    localparam int OPC_W  = 8;
    localparam int IMM_W  = WORD_W - OPC_W;

    typedef enum logic [3:0] {
        K_NONE, K_LDHI, K_LDLO, K_ADD, K_GETACC, K_ID,
        K_WR, K_RD, K_WRACC, K_WRIMM, K_BWR, K_BRD, K_SIB, K_SIBACC
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DATA, ST_WRITE, ST_READ, ST_SEND
    } state_e;
endpackage

// File: rtl/hcd_opdec.sv
module hcd_opdec
    import hcd_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output kind_e            kind
);
    always_comb begin
        unique case (opc)
            8'h55:   kind = K_LDHI;
            8'h6C:   kind = K_LDLO;
            8'h41:   kind = K_ADD;
            8'h61:   kind = K_GETACC;
            8'h70:   kind = K_ID;
            8'h57:   kind = K_WR;
            8'h4C:   kind = K_RD;
            8'h77:   kind = K_WRACC;
            8'h73:   kind = K_WRIMM;
            8'h65:   kind = K_BWR;
            8'h62:   kind = K_BRD;
            8'h64:   kind = K_SIBACC;
            8'h43, 8'h53, 8'h72, 8'h52, 8'h54,
            8'h50, 8'h45, 8'h44, 8'h4F, 8'h75:
                     kind = K_SIB;
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/hcd_accum.sv
module hcd_accum
    import hcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  kind_e             kind,
    input  logic [IMM_W-1:0]  imm,
    output logic [WORD_W-1:0] acc
);
    logic [WORD_W-1:0] imm_sext;
    assign imm_sext = {{(WORD_W-IMM_W){imm[IMM_W-1]}}, imm};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            case (kind)
                K_LDHI:  acc[WORD_W-1:OPC_W] <= imm;
                K_LDLO:  acc[OPC_W-1:0]      <= imm[OPC_W-1:0];
                K_ADD:   acc                 <= acc + imm_sext;
                default: acc                 <= acc;
            endcase
        end
    end
endmodule

// File: rtl/host_cmd_decoder.sv
module host_cmd_decoder
    import hcd_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_WORD = 32'h4843_4430
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [WORD_W-1:0] rsp_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              sib_stb,
    output logic [OPC_W-1:0]  sib_op,
    output logic [WORD_W-1:0] sib_arg,
    output logic              callback
);
    localparam logic [IMM_W-1:0] ONE = IMM_W'(1);

    state_e            state_q, state_d;
    logic [WORD_W-1:0] addr_q, addr_d, wdata_q, wdata_d, rsp_q, rsp_d;
    logic [IMM_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] acc;
    kind_e             kind;

    logic [OPC_W-1:0]  opc;
    logic [IMM_W-1:0]  imm;
    logic [WORD_W-1:0] imm_z;
    logic              take_cmd;

    assign opc      = cmd_data[OPC_W-1:0];
    assign imm      = cmd_data[WORD_W-1:OPC_W];
    assign imm_z    = {{OPC_W{1'b0}}, imm};
    assign take_cmd = (state_q == ST_IDLE) && cmd_valid;

    hcd_opdec u_dec (.opc(opc), .kind(kind));

    hcd_accum u_acc (
        .clk(clk), .rst_n(rst_n), .en(take_cmd),
        .kind(kind), .imm(imm), .acc(acc)
    );

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rsp_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
            rsp_q   <= rsp_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and datapath
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        wdata_d = wdata_q;
        rsp_d   = rsp_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) begin
                case (kind)
                    K_WR:     begin addr_d = imm_z; cnt_d = ONE; state_d = ST_DATA; end
                    K_RD:     begin addr_d = imm_z; cnt_d = ONE; state_d = ST_READ; end
                    K_WRACC:  begin addr_d = imm_z; wdata_d = acc; cnt_d = ONE; state_d = ST_WRITE; end
                    K_WRIMM:  begin addr_d = acc; wdata_d = imm_z; cnt_d = ONE; state_d = ST_WRITE; end
                    K_BWR:    begin addr_d = acc; cnt_d = imm;
                                    state_d = (imm == '0) ? ST_IDLE : ST_DATA; end
                    K_BRD:    begin addr_d = acc; cnt_d = imm;
                                    state_d = (imm == '0) ? ST_IDLE : ST_READ; end
                    K_GETACC: begin rsp_d = acc; cnt_d = ONE; state_d = ST_SEND; end
                    K_ID:     begin rsp_d = ID_WORD; cnt_d = ONE; state_d = ST_SEND; end
                    default:  state_d = ST_IDLE;
                endcase
            end
            ST_DATA: if (cmd_valid) begin
                wdata_d = cmd_data;
                state_d = ST_WRITE;
            end
            ST_WRITE: if (mem_ack) begin
                cnt_d   = cnt_q - ONE;
                addr_d  = addr_q + 1'b1;
                state_d = (cnt_q == ONE) ? ST_IDLE : ST_DATA;
            end
            ST_READ: if (mem_ack) begin
                rsp_d   = mem_rdata;
                state_d = ST_SEND;
            end
            ST_SEND: if (rsp_ready) begin
                cnt_d   = cnt_q - ONE;
                addr_d  = addr_q + 1'b1;
                state_d = (cnt_q == ONE) ? ST_IDLE : ST_READ;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        cmd_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        callback  = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin cmd_ready = 1'b1; callback = 1'b1; end
            ST_DATA:  begin cmd_ready = 1'b1; callback = 1'b1; end
            ST_WRITE: begin mem_req = 1'b1; mem_we = 1'b1; end
            ST_READ:  begin mem_req = 1'b1; end
            ST_SEND:  begin rsp_valid = 1'b1; callback = 1'b1; end
            default:  ;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign rsp_data  = rsp_q;

    // sibling command strobe, one cycle after acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sib_stb <= 1'b0;
            sib_op  <= '0;
            sib_arg <= '0;
        end else begin
            sib_stb <= take_cmd && (kind == K_SIB || kind == K_SIBACC);
            if (take_cmd && (kind == K_SIB || kind == K_SIBACC)) begin
                sib_op  <= opc;
                sib_arg <= (kind == K_SIBACC) ? acc : imm_z;
            end
        end
    end
endmodule

// File: rtl/hcd_checker.sv
module hcd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_data,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        sib_stb,
    input logic        callback
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R11
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !rsp_valid && !mem_req); // R11
    AST_CB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        callback == (cmd_ready || rsp_valid)); // R12
    AST_SIB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sib_stb |-> $past(cmd_valid && cmd_ready)); // R9
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> cmd_ready && !rsp_valid && !mem_req && !sib_stb); // R13
    AST_ACK_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |-> mem_req); // R10
endmodule

bind host_cmd_decoder hcd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .sib_stb(sib_stb),
    .callback(callback)
);

// File: tb/tb_host_cmd_decoder.sv
module tb_host_cmd_decoder;
    localparam logic [31:0] ID = 32'h4843_4430;
    localparam int NV = 43;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, rsp_ready = 1'b0;
    logic [31:0] cmd_data = '0;
    logic cmd_ready, rsp_valid, mem_req, mem_we, sib_stb, callback;
    logic [31:0] rsp_data, mem_addr, mem_wdata, sib_arg;
    logic [7:0] sib_op;
    logic mem_ack;
    logic [31:0] mem_rdata;

    always #2 clk = ~clk;

    host_cmd_decoder #(.ID_WORD(ID)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .sib_stb(sib_stb), .sib_op(sib_op),
        .sib_arg(sib_arg), .callback(callback)
    );

    // memory model with programmable wait cycles
    logic [31:0] mem [256];
    int mem_lat = 0;
    int wcnt;
    int mem_cnt = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
            wcnt <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wcnt >= mem_lat) begin
                    mem_ack <= 1'b1;
                    wcnt <= 0;
                    mem_cnt <= mem_cnt + 1;
                    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
                    else        mem_rdata <= mem[mem_addr[7:0]];
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    // sibling strobe monitor
    int sib_cnt = 0;
    logic [7:0]  sib_last_op = '0;
    logic [31:0] sib_last_arg = '0;
    always @(posedge clk) begin
        if (sib_stb) begin
            sib_cnt <= sib_cnt + 1;
            sib_last_op <= sib_op;
            sib_last_arg <= sib_arg;
        end
    end

    int checks = 0;
    int bad = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        cmd_valid = 1'b1;
        cmd_data = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_data = '0;
    endtask

    task automatic pull(output logic [31:0] got, input int dly);
        rsp_ready = 1'b0;
        repeat (dly) @(negedge clk);
        while (!rsp_valid) @(negedge clk);
        got = rsp_data;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    // bit 32 set: expect this response word; clear: push this word
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 32'h0000_1055}, {1'b0, 32'h0000_206C}, {1'b0, 32'h0000_0061},
        {1'b1, 32'h0000_1020},                                             // 3  R2
        {1'b0, 32'h0000_0557}, {1'b0, 32'hDEAD_BEEF}, {1'b0, 32'h0000_054C},
        {1'b1, 32'hDEAD_BEEF},                                             // 7  R4
        {1'b0, 32'h0000_0777}, {1'b0, 32'h0000_074C},
        {1'b1, 32'h0000_1020},                                             // 10 R5
        {1'b0, 32'hABCD_EF73}, {1'b0, 32'h0000_204C},
        {1'b1, 32'h00AB_CDEF},                                             // 13 R5
        {1'b0, 32'hFFFF_FF41}, {1'b0, 32'h0000_0061},
        {1'b1, 32'h0000_101F},                                             // 16 R3
        {1'b0, 32'h0000_0541}, {1'b0, 32'h0000_0365},
        {1'b0, 32'h1111_1111}, {1'b0, 32'h2222_2222}, {1'b0, 32'h3333_3333},
        {1'b0, 32'h0000_0362},
        {1'b1, 32'h1111_1111}, {1'b1, 32'h2222_2222}, {1'b1, 32'h3333_3333}, // 23-25 R7
        {1'b0, 32'h0000_254C},
        {1'b1, 32'h2222_2222},                                             // 27 R6
        {1'b0, 32'h0000_0070},
        {1'b1, ID},                                                        // 29 R8
        {1'b0, 32'h1234_56FF}, {1'b0, 32'h0000_0065}, {1'b0, 32'h0000_0062},
        {1'b0, 32'h0000_0061},
        {1'b1, 32'h0000_1024},                                             // 34 R1
        {1'b0, 32'hFFFF_FF55}, {1'b0, 32'h0000_FF6C}, {1'b0, 32'h0000_0141},
        {1'b0, 32'h0000_0061},
        {1'b1, 32'h0000_0000},                                             // 39 R3
        {1'b0, 32'h7FFF_FF41}, {1'b0, 32'h0000_0061},
        {1'b1, 32'h007F_FFFF}                                              // 42 R3
    };
    localparam int VTAG [NV] = '{
        0,0,0,2, 0,0,0,4, 0,0,5, 0,0,5, 0,0,3, 0,0,0,0,0,0, 7,7,7, 0,6,
        0,8, 0,0,0,0,1, 0,0,0,0,3, 0,0,3
    };

    initial begin
        logic [31:0] got, d0;
        repeat (3) @(negedge clk);
        // R13: idle outputs after reset
        check(cmd_ready && !rsp_valid && !mem_req && !sib_stb, "R13 reset state",
              {28'd0, cmd_ready, rsp_valid, mem_req, sib_stb}, 32'h8);
        check(callback == 1'b1, "R12 callback after reset", {31'd0, callback}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][32]) begin
                pull(got, i % 3);
                check(got == VEC[i][31:0], $sformatf("R%0d vec%0d", VTAG[i], i), got, VEC[i][31:0]);
            end else begin
                push(VEC[i][31:0]);
            end
        end

        // R9: sibling forwarding, acc = 0x007FFFFF here
        d0 = sib_cnt;
        push(32'h0000_1254);
        @(negedge clk);
        check(sib_cnt == d0 + 1, "R9 strobe count", sib_cnt, d0 + 1);
        check(sib_last_op == 8'h54 && sib_last_arg == 32'h12, "R9 op/arg timeout",
              {sib_last_op, sib_last_arg[23:0]}, {8'h54, 24'h12});
        push(32'h0000_0064);
        @(negedge clk);
        check(sib_last_op == 8'h64 && sib_last_arg == 32'h007F_FFFF, "R9 acc argument",
              sib_last_arg, 32'h007F_FFFF);
        push(32'h0000_0072);
        @(negedge clk);
        check(sib_last_op == 8'h72 && !rsp_valid, "R9 resume no response",
              {23'd0, rsp_valid, sib_last_op}, 32'h72);

        // R1: unknown opcodes ignored
        d0 = sib_cnt;
        got = mem_cnt;
        push(32'hABCD_EF00);
        push(32'h0000_00FF);
        repeat (3) @(negedge clk);
        check(sib_cnt == d0 && mem_cnt == got, "R1 no strobe or memory access",
              sib_cnt + mem_cnt, d0 + got);
        check(!rsp_valid && cmd_ready, "R1 no response", {30'd0, rsp_valid, cmd_ready}, 32'd1);
        push(32'h0000_0061);
        pull(got, 0);
        check(got == 32'h007F_FFFF, "R1 accumulator unchanged", got, 32'h007F_FFFF);

        // R10/R12: slow memory, request held
        mem_lat = 3;
        push(32'h0000_3057);
        check(cmd_ready && callback, "R12 callback in data phase",
              {30'd0, cmd_ready, callback}, 32'd3);
        push(32'hCAFE_F00D);
        check(mem_req && mem_we && mem_addr == 32'h30 && !callback && !cmd_ready,
              "R12 busy during write", mem_addr, 32'h30);
        @(negedge clk);
        check(mem_req && mem_addr == 32'h30 && mem_wdata == 32'hCAFE_F00D,
              "R10 request held", mem_wdata, 32'hCAFE_F00D);
        push(32'h0000_304C);
        pull(got, 0);
        check(got == 32'hCAFE_F00D, "R4 readback with wait cycles", got, 32'hCAFE_F00D);
        mem_lat = 0;

        // R11: response backpressure
        push(32'h0000_0061);
        while (!rsp_valid) @(negedge clk);
        d0 = rsp_data;
        repeat (4) @(negedge clk);
        check(rsp_valid && rsp_data == d0 && !cmd_ready && callback,
              "R11 response held", rsp_data, d0);
        pull(got, 0);
        check(got == 32'h007F_FFFF, "R11 held value correct", got, 32'h007F_FFFF);

        // R13: reset in the middle of a read
        mem_lat = 3;
        push(32'h0000_304C);
        rst_n = 1'b0;
        @(negedge clk);
        check(cmd_ready && !mem_req && !rsp_valid, "R13 reset mid-read",
              {29'd0, cmd_ready, mem_req, rsp_valid}, 32'd4);
        rst_n = 1'b1;
        mem_lat = 0;
        @(negedge clk);
        push(32'h0000_0061);
        pull(got, 0);
        check(got == 32'h0, "R2 accumulator cleared by reset", got, 32'h0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule